// File: doc/BRIEF.md
# Oversampling Serial Receiver with Standby Wakeup

This block recovers characters from an asynchronous NRZ serial line. It runs on the system clock. A one-cycle enable pulse arrives sixteen times per bit period, and each pulse advances the bit-phase logic by one step. The serial input must already be synchronized to the clock. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. The data width is chosen by a mode input.

Each bit value is decided by a majority vote over several sub-bit samples. The receiver reports disagreeing samples as noise and a low stop bit as a framing error. It reports overrun when a new character completes while the previous one is still unread. The internal bit phase is realigned on every falling edge inside a frame, so a transmitter somewhat faster or slower than nominal is still received. On a multidrop line, software can put the receiver into standby. In standby, completed characters are discarded. Standby ends by itself after a full frame time of continuous ones, so the first character of the next message is received. The block also drives a level that marks an idle line.

Top module: `uart_oversample_rx`

## Requirements
- R1: The delivered word carries data bit k of the frame in bit k of `rx_data` (least significant bit first). With `nine_bit`=1 it holds 9 data bits. With `nine_bit`=0 it holds 8, and `rx_data[8]` reads 0.
- R2: Tick number 0 is the first tick that sees the line low while the receiver is hunting. Each data bit is decided by a majority of the samples at bit-relative ticks 7, 8 and 9.
- R3: `rx_noise` is set for a word when any voted group of that frame held samples that disagreed. This covers the start bit, every data bit and the stop bit.
- R4: The start and stop bits are each decided by a majority of 7 samples at bit-relative ticks 5 to 11. A single wrong sample changes neither bit.
- R5: `rx_frame_err` is set for a word whose voted stop bit is 0. That word is still delivered.
- R6: A start bit whose vote is 1 is discarded as a false start. No word is produced, and the receiver hunts for a new low level.
- R7: Every high-to-low transition inside the data bits realigns the bit phase. Frames with bit periods of 15 or 17 ticks and a falling edge at least every second bit are received correctly.
- R8: `rx_overrun` is set when a word completes while `rx_valid` is still 1 and `rd_ack` is not asserted. The unread word is kept. A one-cycle `rd_ack` clears both `rx_valid` and `rx_overrun`.
- R9: `line_idle` becomes 1 after 16×(data bits + 2) consecutive ticks that see the line high. It returns to 0 on the first tick that sees the line low.
- R10: A `standby_req` pulse sets `in_standby`. While it is set, completed frames change neither `rx_valid` nor `rx_data`. It clears itself on the tick at which the consecutive-high count reaches the idle threshold of R9.
- R11: After reset, `rx_valid`, all three error flags, `line_idle` and `in_standby` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| rx_line | input | 1 | Synchronized serial input, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| standby_req | input | 1 | One-cycle request to enter standby |
| rd_ack | input | 1 | One-cycle pulse that consumes the held word |
| rx_data | output | 9 | Last accepted word |
| rx_valid | output | 1 | A word is held and has not been consumed |
| rx_noise | output | 1 | Noise seen in the held word's frame |
| rx_frame_err | output | 1 | Held word had a low stop bit |
| rx_overrun | output | 1 | A word was lost while the held one was unread |
| line_idle | output | 1 | The line has been high for a full frame time |
| in_standby | output | 1 | Receiver is discarding characters |

## Verification
The bench corrupts one sample at a time in a data bit, in the start bit and in the stop bit. A receiver that trusted a single sample would then deliver a wrong value or drop the character, and one that ignored disagreement would leave the noise flag clear. It sends 0x55 with bit periods of 15 and 17 ticks. Without edge realignment the sample point drifts out of the bit and the word comes back corrupted. It also sends a short low glitch, which must not produce a word, and a low stop bit, whose word must arrive flagged and must not spawn a phantom character. Finally it leaves a word unread while a second one arrives, expecting the first word to survive, and it checks that frames sent in standby disappear until a full idle time has passed.

// File: rtl/uor_pkg.sv
package uor_pkg;

    localparam int WORD_W = 9;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

endpackage

// File: rtl/uor_idle_watch.sv
module uor_idle_watch #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rx_i,
    input  logic nine_i,
    output logic idle_o,
    output logic idle_rise_o
);

    localparam int MAX_RUN = OSR * 11;
    localparam int CW      = $clog2(MAX_RUN + 1);

    typedef struct packed {
        logic [CW-1:0] run;
    } idle_s;

    idle_s q, d;
    logic [CW-1:0] thr;

    always_comb begin
        thr         = nine_i ? CW'(OSR * 11) : CW'(OSR * 10);
        d           = q;
        idle_rise_o = 1'b0;
        if (tick_i) begin
            if (!rx_i) begin
                d.run = '0;
            end else if (q.run < thr) begin
                d.run = q.run + 1'b1;
                idle_rise_o = (q.run + 1'b1 == thr);
            end
        end
        idle_o = (q.run >= thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9: a low sample on a tick ends the idle indication
    p_idle_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !rx_i) |=> !idle_o);

endmodule

// File: rtl/uor_frame_fsm.sv
module uor_frame_fsm
    import uor_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              nine_i,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o,
    output logic              noise_o,
    output logic              ferr_o
);

    localparam int PW = $clog2(OSR);
    localparam logic [PW-1:0] MID   = PW'(OSR / 2);
    localparam logic [PW-1:0] D_LO  = MID - PW'(1);
    localparam logic [PW-1:0] D_HI  = MID + PW'(1);
    localparam logic [PW-1:0] F_LO  = MID - PW'(3);
    localparam logic [PW-1:0] F_HI  = MID + PW'(3);
    localparam logic [PW-1:0] PH_LAST = PW'(OSR - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [PW-1:0]     ph;
        logic [3:0]        bidx;
        logic [2:0]        ones;
        logic [WORD_W-1:0] sh;
        logic              noise;
        logic              prev;
        logic              done;
        logic [WORD_W-1:0] word;
        logic              noise_out;
        logic              ferr;
    } fsm_s;

    fsm_s q, d;

    logic          in_f, in_d, fall;
    logic [2:0]    n_ones;
    logic [3:0]    last_bit;
    logic [PW-1:0] ph_nx;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        in_f     = (q.ph >= F_LO) && (q.ph <= F_HI);
        in_d     = (q.ph >= D_LO) && (q.ph <= D_HI);
        fall     = q.prev && !rx_i;
        last_bit = nine_i ? 4'd8 : 4'd7;
        ph_nx    = (q.ph == PH_LAST) ? '0 : q.ph + 1'b1;
        n_ones   = q.ones;
        if (tick_i) begin
            d.prev = rx_i;
            unique case (q.st)
                ST_HUNT: begin
                    if (!rx_i) begin
                        d.st    = ST_START;
                        d.ph    = PW'(1);
                        d.ones  = '0;
                        d.noise = 1'b0;
                    end
                end
                ST_START: begin
                    d.ph = ph_nx;
                    if (in_f) n_ones = q.ones + {2'b00, rx_i};
                    d.ones = n_ones;
                    if (q.ph == F_HI) begin
                        if (n_ones >= 3'd4) d.st = ST_HUNT;
                        else                d.noise = (n_ones != 3'd0);
                    end
                    if (q.ph == PH_LAST) begin
                        d.st   = ST_DATA;
                        d.bidx = '0;
                        d.ones = '0;
                    end
                end
                ST_DATA: begin
                    d.ph = ph_nx;
                    if (in_d) n_ones = q.ones + {2'b00, rx_i};
                    d.ones = n_ones;
                    if (q.ph == D_HI) begin
                        d.sh = {(n_ones >= 3'd2), q.sh[WORD_W-1:1]};
                        if (n_ones != 3'd0 && n_ones != 3'd3) d.noise = 1'b1;
                    end
                    if (q.ph == PH_LAST) begin
                        d.ones = '0;
                        if (q.bidx == last_bit) d.st = ST_STOP;
                        else                    d.bidx = q.bidx + 1'b1;
                    end
                    if (fall) begin
                        if (q.ph != '0 && q.ph < D_LO) begin
                            d.ph   = PW'(1);
                            d.ones = '0;
                        end else if (q.ph > D_HI) begin
                            d.ph   = PW'(1);
                            d.ones = '0;
                            if (q.bidx == last_bit) d.st = ST_STOP;
                            else                    d.bidx = q.bidx + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    d.ph = ph_nx;
                    if (in_f) n_ones = q.ones + {2'b00, rx_i};
                    d.ones = n_ones;
                    if (q.ph == F_HI) begin
                        d.done      = 1'b1;
                        d.word      = nine_i ? q.sh : {1'b0, q.sh[WORD_W-1:1]};
                        d.ferr      = (n_ones < 3'd4);
                        d.noise_out = q.noise | (n_ones != 3'd0 && n_ones != 3'd7);
                        d.st        = ST_HUNT;
                        d.ones      = '0;
                    end
                end
                default: d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_HUNT;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done_o  = q.done;
    assign word_o  = q.word;
    assign noise_o = q.noise_out;
    assign ferr_o  = q.ferr;

    // R5: a completed frame is only ever reported right after an enable tick
    p_done_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(tick_i));

    // R6: a start bit that votes high sends the receiver back to hunting
    p_false_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_START && tick_i && q.ph == F_HI && rx_i && q.ones >= 3'd3)
        |=> (q.st == ST_HUNT));

    // R7: an early falling edge inside a data bit pulls the phase back to the bit start
    p_resync_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && tick_i && q.prev && !rx_i && q.ph != '0 && q.ph < D_LO)
        |=> (q.ph == PW'(1) && q.st == ST_DATA));

endmodule

// File: rtl/uart_oversample_rx.sv
module uart_oversample_rx
    import uor_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_line,
    input  logic              nine_bit,
    input  logic              standby_req,
    input  logic              rd_ack,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_noise,
    output logic              rx_frame_err,
    output logic              rx_overrun,
    output logic              line_idle,
    output logic              in_standby
);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              valid;
        logic              noise;
        logic              ferr;
        logic              ovr;
        logic              stby;
    } hold_s;

    hold_s q, d;

    logic              fr_done, fr_noise, fr_ferr, idle_rise;
    logic [WORD_W-1:0] fr_word;

    uor_frame_fsm #(.OSR(OSR)) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (os_tick),
        .rx_i    (rx_line),
        .nine_i  (nine_bit),
        .done_o  (fr_done),
        .word_o  (fr_word),
        .noise_o (fr_noise),
        .ferr_o  (fr_ferr)
    );

    uor_idle_watch #(.OSR(OSR)) i_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (os_tick),
        .rx_i        (rx_line),
        .nine_i      (nine_bit),
        .idle_o      (line_idle),
        .idle_rise_o (idle_rise)
    );

    always_comb begin
        d = q;
        if (rd_ack) begin
            d.valid = 1'b0;
            d.ovr   = 1'b0;
        end
        if (idle_rise)   d.stby = 1'b0;
        if (standby_req) d.stby = 1'b1;
        if (fr_done && !q.stby) begin
            if (d.valid) begin
                d.ovr = 1'b1;
            end else begin
                d.data  = fr_word;
                d.noise = fr_noise;
                d.ferr  = fr_ferr;
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data      = q.data;
    assign rx_valid     = q.valid;
    assign rx_noise     = q.noise;
    assign rx_frame_err = q.ferr;
    assign rx_overrun   = q.ovr;
    assign in_standby   = q.stby;

    // R8: an unread word survives a second completed frame
    p_keep_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_ack && fr_done && !in_standby) |=> ($stable(rx_data) && rx_overrun));

    // R8: a consume pulse with no frame completing empties the holding register
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !fr_done) |=> (!rx_valid && !rx_overrun));

    // R10: in standby a completed frame does not raise the valid flag
    p_standby_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && fr_done && !rx_valid) |=> !rx_valid);

endmodule

// File: tb/test_uart_oversample_rx.sv
module test_uart_oversample_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       nine_bit = 1'b0;
    logic       standby_req = 1'b0;
    logic       rd_ack = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, rx_noise, rx_frame_err, rx_overrun, line_idle, in_standby;

    int vectors = 0;
    int errors  = 0;
    bit auto_read = 1'b1;
    bit finished  = 1'b0;
    logic [10:0] exp_q[$];   // {ferr, noise, data[8:0]}

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) os_tick <= 1'b0;
        else        os_tick <= ~os_tick;
    end

    uart_oversample_rx i_uart_oversample_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_tick      (os_tick),
        .rx_line      (rx_line),
        .nine_bit     (nine_bit),
        .standby_req  (standby_req),
        .rd_ack       (rd_ack),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_noise     (rx_noise),
        .rx_frame_err (rx_frame_err),
        .rx_overrun   (rx_overrun),
        .line_idle    (line_idle),
        .in_standby   (in_standby)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick_with(input logic v);
        @(negedge clk);
        while (!os_tick) @(negedge clk);
        rx_line = v;
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n * 16; i++) tick_with(1'b1);
    endtask

    // gbit: frame bit index to corrupt (0 = start), gpos: tick inside that bit
    task automatic send_frame(input logic [8:0] data, input int tpb, input int gbit,
                              input int gpos, input logic stopv, input bit expect_out);
        int nb;
        logic [10:0] bits;
        nb = nine_bit ? 9 : 8;
        bits = '0;
        for (int k = 0; k < nb; k++) bits[k+1] = data[k];
        bits[nb+1] = stopv;
        if (expect_out)
            exp_q.push_back({~stopv, (gbit >= 0), nine_bit ? data : {1'b0, data[7:0]}});
        for (int b = 0; b < nb + 2; b++)
            for (int t = 0; t < tpb; t++)
                tick_with((b == gbit && t == gpos) ? ~bits[b] : bits[b]);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (auto_read && rx_valid && rst_n) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected word", int'(rx_data), 0);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    check(rx_data == e[8:0], "R1/R2/R7 data", int'(rx_data), int'(e[8:0]));
                    check(rx_noise == e[9], "R3 noise", int'(rx_noise), int'(e[9]));
                    check(rx_frame_err == e[10], "R5 framing", int'(rx_frame_err), int'(e[10]));
                end
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
            end
        end
    end

    initial begin
        #3000000;
        if (!finished) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check(rx_valid == 0 && rx_noise == 0 && rx_frame_err == 0 && rx_overrun == 0
              && line_idle == 0 && in_standby == 0, "R11 reset", int'(rx_valid), 0);
        rst_n = 1'b1;
        idle_bits(11);
        // R9: idle after a full frame time of ones
        check(line_idle == 1, "R9 idle set", int'(line_idle), 1);

        // R1 R2: plain 8-bit frames
        send_frame(9'h0A5, 16, -1, 0, 1'b1, 1'b1); idle_bits(2);
        send_frame(9'h03C, 16, -1, 0, 1'b1, 1'b1); idle_bits(2);
        // R1: 8-bit mode drops bit 8
        send_frame(9'h1FF, 16, -1, 0, 1'b1, 1'b1); idle_bits(2);
        // R1: 9-bit mode
        nine_bit = 1'b1;
        send_frame(9'h1A5, 16, -1, 0, 1'b1, 1'b1); idle_bits(2);
        send_frame(9'h0C3, 16, -1, 0, 1'b1, 1'b1); idle_bits(2);
        nine_bit = 1'b0;

        // R2 R3: one flipped centre sample in data bit 2
        send_frame(9'h0F0, 16, 3, 8, 1'b1, 1'b1); idle_bits(2);
        // R4 R3: one flipped sample in the start bit
        send_frame(9'h05A, 16, 0, 6, 1'b1, 1'b1); idle_bits(2);
        // R4 R3: one flipped sample in the stop bit
        send_frame(9'h081, 16, 9, 10, 1'b1, 1'b1); idle_bits(2);

        // R5: low stop bit, word delivered flagged, no phantom word
        send_frame(9'h033, 16, -1, 0, 1'b0, 1'b1); idle_bits(3);
        check(exp_q.size() == 0 && rx_valid == 0, "R5 no phantom", int'(rx_valid), 0);

        // R6: short low glitch is a false start
        for (int i = 0; i < 3; i++) tick_with(1'b0);
        idle_bits(2);
        check(rx_valid == 0, "R6 false start", int'(rx_valid), 0);

        // R9: idle drops after low traffic, returns after a frame time
        send_frame(9'h000, 16, -1, 0, 1'b1, 1'b1); idle_bits(1);
        check(line_idle == 0, "R9 idle cleared", int'(line_idle), 0);
        idle_bits(10);
        check(line_idle == 1, "R9 idle regained", int'(line_idle), 1);

        // R7: baud mismatch both ways
        send_frame(9'h055, 17, -1, 0, 1'b1, 1'b1); idle_bits(2);
        send_frame(9'h055, 15, -1, 0, 1'b1, 1'b1); idle_bits(2);

        // R8: overrun keeps the first word
        auto_read = 1'b0;
        send_frame(9'h011, 16, -1, 0, 1'b1, 1'b1); idle_bits(1);
        send_frame(9'h0EE, 16, -1, 0, 1'b1, 1'b0); idle_bits(1);
        check(rx_valid == 1, "R8 still valid", int'(rx_valid), 1);
        check(rx_overrun == 1, "R8 overrun", int'(rx_overrun), 1);
        check(rx_data == 9'h011, "R8 old word kept", int'(rx_data), 'h11);
        auto_read = 1'b1;
        repeat (6) @(negedge clk);
        check(rx_overrun == 0 && rx_valid == 0, "R8 cleared by read", int'(rx_overrun), 0);
        idle_bits(11);

        // R10: standby discards frames until a fresh idle time
        @(negedge clk); standby_req = 1'b1;
        @(negedge clk); standby_req = 1'b0;
        check(in_standby == 1, "R10 standby entered", int'(in_standby), 1);
        send_frame(9'h066, 16, -1, 0, 1'b1, 1'b0); idle_bits(2);
        send_frame(9'h099, 16, -1, 0, 1'b1, 1'b0); idle_bits(1);
        check(rx_valid == 0 && in_standby == 1, "R10 frames ignored", int'(rx_valid), 0);
        idle_bits(11);
        check(in_standby == 0, "R10 woke on idle", int'(in_standby), 0);
        send_frame(9'h0B7, 16, -1, 0, 1'b1, 1'b1); idle_bits(2);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R1 all words seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule